// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block owns the program counter of a shader core and the small return stack behind its structured control flow. Each cycle that it is fetching, it looks at the 32-bit instruction word held at its current address and picks the next address. It handles plain jumps, calls that come back on their own after a fixed number of instructions, if/else regions written as a target plus a skip length, counted loops driven by an integer uniform, breaks out of the innermost loop, and program end. Branch conditions come from two places: a single condition bit from the compare unit, and a bank of uniform booleans selected by a field in the instruction.

Calls, ifs and loops each push a frame that records the address where the region ends. The sequencer compares every new address with the end address of the top frame. On a match it spends one non-fetch cycle resolving that frame: it returns, skips the else part, or runs the loop again. When several frames end at the same address they are resolved one per cycle. The state machine has four states. S_IDLE waits after reset. S_RUN fetches and executes. S_UNWIND resolves one frame per cycle. S_HALT holds after an end opcode. The transitions are: start (S_IDLE or S_HALT to S_RUN), region_hit (S_RUN to S_UNWIND), unwind_more (stays in S_UNWIND), unwind_done (S_UNWIND to S_RUN) and finish (S_RUN to S_HALT).

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, `fetch`, `done`, `ovf_err`, `pc` and `loop_ctr` are all zero. A `start` pulse in idle or halt loads `entry_pc` into `pc`, and fetching begins on the next cycle.
- R2: An instruction whose opcode (bits 31:26) is not a flow opcode advances `pc` by one.
- R3: Opcode 0x2C jumps to the target (bits 21:10) when `cond` is 1. Opcode 0x2D jumps there when `ubool[id]` is 1, where id is bits 25:22. When the condition is false, both fall through to `pc`+1.
- R4: A taken call runs target through target+NUM-1 and then resumes at the call address plus one. NUM is bits 7:0. Opcode 0x24 always calls, 0x25 calls when `cond` is 1, and 0x26 calls when `ubool[id]` is 1. An untaken call falls through.
- R5: A true if runs from the next address up to target-1 and then continues at target+NUM. A false if goes straight to the target. Opcode 0x28 tests `cond`; opcode 0x27 tests `ubool[id]`.
- R6: Opcode 0x29 reads integer uniform id[1:0], with x in bits 7:0, y in bits 15:8 and z in bits 23:16. It sets `loop_ctr` to y and runs the body from the next address through the target. After each pass it adds z, and it repeats while the new value is at most y+x. When the loop ends, execution continues at target+1 and `loop_ctr` keeps its last value.
- R7: Opcode 0x23 with `cond` = 1 discards every frame down to and including the innermost loop frame and continues at that loop's exit address. With `cond` = 0, or with no loop frame open, it falls through.
- R8: Opcodes 0x21 and 0x22 stop fetching and raise `done`. `pc` then holds until the next `start`.
- R9: The stack holds 4 frames. A push onto a full stack stores nothing, but the branch still goes to its target. The push also sets `ovf_err`, which stays set until the next `start`.
- R10: Each frame resolved at a region end costs exactly one non-fetch cycle. Frames that end at the same address are resolved on consecutive cycles.
- R11: A loop whose step leaves the counter within its limit stops after 256 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at `entry_pc` |
| entry_pc | input | 12 | First instruction address |
| insn | input | 32 | Instruction word at `pc` |
| cond | input | 1 | Condition bit from the compare unit |
| ubool | input | 16 | Uniform booleans |
| int_unif | input | 96 | Four integer uniforms, 24 bits each (z,y,x) |
| pc | output | 12 | Current instruction address |
| fetch | output | 1 | `insn` is being executed this cycle |
| done | output | 1 | Program ended |
| ovf_err | output | 1 | Sticky stack overflow flag |
| loop_ctr | output | 8 | Loop counter register |

## Verification
The next address appears on `pc` one clock after the instruction at the current address is consumed. Every region end inserts exactly one cycle in which `fetch` is low. The bench therefore compares only the addresses seen in fetch cycles against a queue of expected addresses, and it counts the non-fetch cycles separately to check the cost of region ends. `done`, `loop_ctr` and `ovf_err` are read once the program has halted, one cycle after the end opcode is fetched. The flag clear on restart is read one cycle after `start` is captured.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    parameter int PC_W  = 12;
    parameter int CNT_W = 8;

    localparam logic [5:0] OP_FIN_A  = 6'h21;
    localparam logic [5:0] OP_FIN_B  = 6'h22;
    localparam logic [5:0] OP_BRK_C  = 6'h23;
    localparam logic [5:0] OP_SUB    = 6'h24;
    localparam logic [5:0] OP_SUB_C  = 6'h25;
    localparam logic [5:0] OP_SUB_U  = 6'h26;
    localparam logic [5:0] OP_IF_U   = 6'h27;
    localparam logic [5:0] OP_IF_C   = 6'h28;
    localparam logic [5:0] OP_REPEAT = 6'h29;
    localparam logic [5:0] OP_JMP_C  = 6'h2C;
    localparam logic [5:0] OP_JMP_U  = 6'h2D;

    typedef enum logic [1:0] {K_CALL, K_IF, K_LOOP, K_NONE} kind_t;

    typedef struct packed {
        kind_t              kind;
        logic [PC_W-1:0]    endp;
        logic [PC_W-1:0]    ret;
        logic [CNT_W:0]     limit;
        logic [CNT_W-1:0]   step;
        logic [CNT_W-1:0]   passes;
        logic [CNT_W-1:0]   cnt;
    } frame_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_UNWIND, S_HALT} state_t;
endpackage

// File: rtl/sfc_stack.sv
module sfc_stack import sfc_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic           pop,
    input  logic           upd,
    input  logic           cut,
    input  logic [SPW-1:0] cut_sp,
    input  frame_t         wr,
    output logic [SPW-1:0] sp,
    output logic           ovf,
    output frame_t         frames_o [DEPTH]
);
    logic full;
    assign full = (sp == SPW'(DEPTH));
    assign ovf  = push && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sp <= '0;
        else if (clr)              sp <= '0;
        else if (push && !full)    sp <= sp + 1'b1;
        else if (pop && sp != '0)  sp <= sp - 1'b1;
        else if (cut)              sp <= cut_sp;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp == SPW'(g))
                frames_o[g] <= wr;
            else if (!push && !pop && upd && sp == SPW'(g + 1))
                frames_o[g] <= wr;
        end
    end

    AST_SP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SPW'(DEPTH));  // R9
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> sp == SPW'(DEPTH));  // R9
endmodule

// File: rtl/sfc_loop_eval.sv
module sfc_loop_eval import sfc_pkg::*; (
    input  frame_t          fr,
    output logic [CNT_W:0]  sum,
    output logic            again
);
    always_comb begin
        sum   = {1'b0, fr.cnt} + {1'b0, fr.step};
        again = (sum <= fr.limit) && (fr.passes != '1);
    end
endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq import sfc_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int NBOOL = 16,
    parameter int NINT  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [PC_W-1:0]        entry_pc,
    input  logic [31:0]            insn,
    input  logic                   cond,
    input  logic [NBOOL-1:0]       ubool,
    input  logic [NINT*3*CNT_W-1:0] int_unif,
    output logic [PC_W-1:0]        pc,
    output logic                   fetch,
    output logic                   done,
    output logic                   ovf_err,
    output logic [CNT_W-1:0]       loop_ctr
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IDW = $clog2(NINT);
    localparam int VW  = 3 * CNT_W;

    state_t          st, ns;
    logic [PC_W-1:0] npc;
    logic [CNT_W-1:0] al_n;

    logic [5:0]      op;
    logic [7:0]      f_num;
    logic [PC_W-1:0] f_dst;
    logic [3:0]      f_id;
    logic            unused_bits;
    assign op          = insn[31:26];
    assign f_num       = insn[7:0];
    assign f_dst       = insn[21:10];
    assign f_id        = insn[25:22];
    assign unused_bits = ^insn[9:8];

    logic            push, pop, upd, cut, clr, ovf, push_ok;
    logic [SPW-1:0]  cut_sp, sp, nsp;
    frame_t          wr, tf;
    frame_t          ent [DEPTH];
    logic [CNT_W:0]  sum;
    logic            again;

    sfc_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
        .upd(upd), .cut(cut), .cut_sp(cut_sp), .wr(wr), .sp(sp),
        .ovf(ovf), .frames_o(ent)
    );

    sfc_loop_eval u_eval (.fr(tf), .sum(sum), .again(again));

    // selected uniforms and top frame
    logic            ub;
    logic [VW-1:0]   iv;
    logic            found;
    logic [SPW-1:0]  fidx;
    logic [PC_W-1:0] fend;
    always_comb begin
        ub = 1'b0;
        for (int k = 0; k < NBOOL; k++)
            if (f_id == 4'(k)) ub = ubool[k];
        iv = '0;
        for (int k = 0; k < NINT; k++)
            if (f_id[IDW-1:0] == IDW'(k)) iv = int_unif[k*VW +: VW];
        tf = '0;
        found = 1'b0;
        fidx = '0;
        fend = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (SPW'(i + 1) == sp) tf = ent[i];
            if (SPW'(i) < sp && ent[i].kind == K_LOOP) begin
                found = 1'b1;
                fidx  = SPW'(i);
                fend  = ent[i].endp;
            end
        end
    end

    logic            taken, match;
    logic [PC_W-1:0] nend;
    always_comb begin
        ns = st; npc = pc; al_n = loop_ctr;
        push = 1'b0; pop = 1'b0; upd = 1'b0; cut = 1'b0; cut_sp = '0;
        wr = '0; taken = 1'b0;
        clr = (st == S_IDLE || st == S_HALT) && start;
        unique case (st)
            S_IDLE, S_HALT: begin
                if (start) begin
                    ns  = S_RUN;
                    npc = entry_pc;
                end
            end
            S_RUN: begin
                npc = pc + 1'b1;
                case (op)
                    OP_FIN_A, OP_FIN_B: begin
                        ns  = S_HALT;
                        npc = pc;
                    end
                    OP_JMP_C: if (cond) npc = f_dst;
                    OP_JMP_U: if (ub)   npc = f_dst;
                    OP_SUB, OP_SUB_C, OP_SUB_U: begin
                        taken = (op == OP_SUB) || (op == OP_SUB_C && cond) ||
                                (op == OP_SUB_U && ub);
                        if (taken) begin
                            push    = 1'b1;
                            wr.kind = K_CALL;
                            wr.endp = f_dst + PC_W'(f_num);
                            wr.ret  = pc + 1'b1;
                            npc     = f_dst;
                        end
                    end
                    OP_IF_C, OP_IF_U: begin
                        taken = (op == OP_IF_C) ? cond : ub;
                        if (taken) begin
                            push    = 1'b1;
                            wr.kind = K_IF;
                            wr.endp = f_dst;
                            wr.ret  = f_dst + PC_W'(f_num);
                        end else begin
                            npc = f_dst;
                        end
                    end
                    OP_REPEAT: begin
                        push      = 1'b1;
                        wr.kind   = K_LOOP;
                        wr.endp   = f_dst + 1'b1;
                        wr.ret    = pc + 1'b1;
                        wr.limit  = {1'b0, iv[2*CNT_W-1:CNT_W]} + {1'b0, iv[CNT_W-1:0]};
                        wr.step   = iv[3*CNT_W-1:2*CNT_W];
                        wr.passes = '0;
                        wr.cnt    = iv[2*CNT_W-1:CNT_W];
                        al_n      = iv[2*CNT_W-1:CNT_W];
                    end
                    OP_BRK_C: begin
                        if (cond && found) begin
                            cut    = 1'b1;
                            cut_sp = fidx;
                            npc    = fend;
                        end
                    end
                    default: ;
                endcase
            end
            S_UNWIND: begin
                if (tf.kind == K_LOOP && again) begin
                    upd       = 1'b1;
                    wr        = tf;
                    wr.passes = tf.passes + 1'b1;
                    wr.cnt    = sum[CNT_W-1:0];
                    npc       = tf.ret;
                    al_n      = sum[CNT_W-1:0];
                end else if (tf.kind == K_LOOP) begin
                    pop  = 1'b1;
                    al_n = sum[CNT_W-1:0];
                end else begin
                    pop = 1'b1;
                    npc = tf.ret;
                end
            end
        endcase

        push_ok = push && (sp != SPW'(DEPTH));
        if (push_ok)   nsp = sp + 1'b1;
        else if (pop)  nsp = sp - 1'b1;
        else if (cut)  nsp = cut_sp;
        else           nsp = sp;
        nend = '0;
        for (int i = 0; i < DEPTH; i++)
            if (SPW'(i + 1) == nsp) nend = ent[i].endp;
        match = push_ok ? (npc == wr.endp) : (nsp != '0 && nend == npc);

        if (st == S_RUN && ns == S_RUN && match) ns = S_UNWIND;
        if (st == S_UNWIND) ns = match ? S_UNWIND : S_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            pc       <= '0;
            loop_ctr <= '0;
            ovf_err  <= 1'b0;
        end else begin
            st       <= ns;
            pc       <= npc;
            loop_ctr <= al_n;
            if (clr)      ovf_err <= 1'b0;
            else if (ovf) ovf_err <= 1'b1;
        end
    end

    always_comb begin
        fetch = (st == S_RUN);
        done  = (st == S_HALT);
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (fetch && pc == $past(entry_pc)));  // R1
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pc)));  // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !start) |=> ovf_err);  // R9
    AST_CTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch && !$past(fetch) && !start && st != S_UNWIND) |=> $stable(loop_ctr));  // R6
endmodule

// File: tb/tb_shader_flow_seq.sv
module tb_shader_flow_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] entry_pc = '0;
    logic [31:0] insn;
    logic        cond = 1'b0;
    logic [15:0] ubool = '0;
    logic [95:0] int_unif = '0;
    logic [11:0] pc;
    logic        fetch, done, ovf_err;
    logic [7:0]  loop_ctr;

    logic [31:0] imem [64];
    assign insn = imem[pc[5:0]];

    shader_flow_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
        .insn(insn), .cond(cond), .ubool(ubool), .int_unif(int_unif),
        .pc(pc), .fetch(fetch), .done(done), .ovf_err(ovf_err),
        .loop_ctr(loop_ctr)
    );

    always #4 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    exp_q [$];
    int    bubbles = 0;
    bit    arm = 0;
    string cur = "R2";
    int    cycles = 0;

    localparam logic [31:0] NOP = 32'h4C00_0000;

    function automatic logic [31:0] br(logic [5:0] op, int dst, int num, int id);
        return {op, 4'(id), 12'(dst), 2'b00, 8'(num)};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: scoreboard of fetched addresses and non-fetch cycles
    always @(negedge clk) begin
        if (rst_n && fetch) begin
            if (exp_q.size() == 0) chk(0, cur, int'(pc), -1);
            else begin
                automatic int e = exp_q.pop_front();
                chk(int'(pc) == e, cur, int'(pc), e);
            end
        end
        if (arm && !fetch && !done) bubbles++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) imem[i] = NOP;
    endtask

    task automatic expect_pc(int a);
        exp_q.push_back(a);
    endtask

    task automatic run_prog(string tag, int bub_exp);
        int n;
        cur = tag;
        bubbles = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0; arm = 1'b1;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        arm = 1'b0;
        chk(done == 1'b1, {tag, " done"}, int'(done), 1);
        chk(exp_q.size() == 0, {tag, " trace left"}, exp_q.size(), 0);
        if (bub_exp >= 0) chk(bubbles == bub_exp, {tag, " bubbles R10"}, bubbles, bub_exp);
        exp_q.delete();
    endtask

    initial begin
        clear_mem();
        int_unif = {24'd0, 24'd0, {8'd1, 8'd5, 8'd2}, {8'd1, 8'd0, 8'd10}};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!fetch && !done && !ovf_err, "R1 reset flags", int'({fetch, done, ovf_err}), 0);
        chk(pc == 0 && loop_ctr == 0, "R1 reset pc", int'(pc), 0);

        // R2/R3 taken jumps, end variant 0x21
        clear_mem();
        cond = 1'b1; ubool = 16'h0004;
        imem[1]  = br(6'h2C, 5, 0, 0);
        imem[5]  = br(6'h2D, 9, 0, 3);
        imem[6]  = br(6'h2D, 10, 0, 2);
        imem[10] = br(6'h21, 0, 0, 0);
        foreach (exp_q[i]) ;
        expect_pc(0); expect_pc(1); expect_pc(5); expect_pc(6); expect_pc(10);
        run_prog("R3", 0);
        // R8 halt holds
        repeat (5) @(negedge clk);
        chk(done && !fetch && pc == 10, "R8 halt hold", int'(pc), 10);

        // untaken branches R3 R4 R5 R7
        clear_mem();
        cond = 1'b0;
        imem[0] = br(6'h2C, 7, 0, 0);
        imem[1] = br(6'h25, 20, 2, 0);
        imem[2] = br(6'h28, 5, 3, 0);
        imem[5] = br(6'h23, 0, 0, 0);
        imem[6] = br(6'h22, 0, 0, 0);
        expect_pc(0); expect_pc(1); expect_pc(2); expect_pc(5); expect_pc(6);
        run_prog("R4 R5 R7 untaken", 0);

        // calls and ifs taken R4 R5
        clear_mem();
        cond = 1'b1; ubool = 16'h0001;
        imem[0]  = br(6'h24, 10, 3, 0);
        imem[1]  = br(6'h26, 20, 1, 0);
        imem[2]  = br(6'h28, 5, 2, 0);
        imem[7]  = br(6'h27, 9, 1, 1);
        imem[9]  = br(6'h22, 0, 0, 0);
        expect_pc(0); expect_pc(10); expect_pc(11); expect_pc(12); expect_pc(1);
        expect_pc(20); expect_pc(2); expect_pc(3); expect_pc(4); expect_pc(7); expect_pc(9);
        run_prog("R4 R5 taken", 3);

        // counted loop R6
        clear_mem();
        imem[0] = br(6'h29, 2, 0, 1);
        imem[3] = br(6'h22, 0, 0, 0);
        expect_pc(0);
        for (int k = 0; k < 3; k++) begin expect_pc(1); expect_pc(2); end
        expect_pc(3);
        run_prog("R6", 3);
        chk(loop_ctr == 8, "R6 counter kept", int'(loop_ctr), 8);

        // break through an open if R7
        clear_mem();
        cond = 1'b1;
        imem[0] = br(6'h29, 5, 0, 0);
        imem[1] = br(6'h28, 4, 0, 0);
        imem[2] = br(6'h23, 0, 0, 0);
        imem[6] = br(6'h22, 0, 0, 0);
        expect_pc(0); expect_pc(1); expect_pc(2); expect_pc(6);
        run_prog("R7", 0);
        chk(loop_ctr == 0, "R7 counter", int'(loop_ctr), 0);

        // coinciding region ends R10
        clear_mem();
        imem[0] = br(6'h28, 4, 2, 0);
        imem[1] = br(6'h28, 3, 1, 0);
        imem[6] = br(6'h22, 0, 0, 0);
        expect_pc(0); expect_pc(1); expect_pc(2); expect_pc(6);
        run_prog("R10", 2);

        // overflow R9
        clear_mem();
        imem[0]  = br(6'h24, 10, 5, 0);
        imem[10] = br(6'h24, 20, 5, 0);
        imem[20] = br(6'h24, 30, 1, 0);
        imem[30] = br(6'h24, 40, 1, 0);
        imem[40] = br(6'h24, 50, 1, 0);
        imem[50] = br(6'h22, 0, 0, 0);
        expect_pc(0); expect_pc(10); expect_pc(20); expect_pc(30); expect_pc(40); expect_pc(50);
        run_prog("R9", 0);
        chk(ovf_err == 1'b1, "R9 flag set", int'(ovf_err), 1);
        repeat (3) @(negedge clk);
        chk(ovf_err == 1'b1, "R9 flag sticky", int'(ovf_err), 1);

        // zero step cap R11 (also clears flag on start)
        clear_mem();
        imem[0] = br(6'h29, 1, 0, 2);
        imem[2] = br(6'h22, 0, 0, 0);
        expect_pc(0);
        for (int k = 0; k < 256; k++) expect_pc(1);
        expect_pc(2);
        fork
            run_prog("R11", 256);
            begin
                @(posedge clk); @(posedge clk); @(negedge clk); @(negedge clk);
                chk(ovf_err == 1'b0, "R9 flag cleared", int'(ovf_err), 0);
            end
        join
        chk(loop_ctr == 0, "R11 counter", int'(loop_ctr), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule